// File: doc/BRIEF.md
# Vector Element Merge Unit

This block decides, element by element, what ends up in the destination vector register after a vector operation. Every element has a small select code from the mask register. The code picks one of several outcomes: keep the previous destination contents, take the freshly computed value, clear the element to zero, set it to all ones, or combine old and new with a bitwise OR or AND.

The unit sits between the vector ALU and the register file write port. It receives the old destination vector, the newly computed vector and a packed vector of select codes, together with a valid strobe. One clock later it presents the merged vector, a valid flag and one write enable per element. A parameter sets the code width to two or three bits. In two-bit mode the upper code bit is forced to zero, so only keep, compute and zero are available.

Top module: `vmerge_unit`

## Requirements
- R1: After reset, out_valid and every bit of out_wen are 0.
- R2: Output lanes, out_valid and out_wen register the inputs sampled on an edge where in_valid is 1, and appear after exactly one clock. On an edge where in_valid is 0, out_valid is 0 and out_wen is all zeros.
- R3: Code 3'b000 (keep) drives the old element value on the output and clears that element's write enable.
- R4: Codes 3'b001, 3'b011 and 3'b111 drive the new element value.
- R5: Code 3'b010 drives an all-zero element.
- R6: Code 3'b100 drives the bitwise OR of the old and new element values.
- R7: Code 3'b101 drives the bitwise AND of the old and new element values.
- R8: Code 3'b110 drives an all-ones element.
- R9: For every code other than 3'b000, the element's write enable is 1 when the output is valid.
- R10: With CODE_W=2 the upper code bit is taken as 0. Code 2'b11 then writes the new value.
- R11: Element i occupies bits [i*ELEM_W +: ELEM_W] of each data vector. Its code occupies bits [i*CODE_W +: CODE_W] of in_mask. Each element is merged independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input vectors are valid this cycle |
| in_old | input | NUM_ELEM*ELEM_W | Current destination vector |
| in_new | input | NUM_ELEM*ELEM_W | Newly computed vector |
| in_mask | input | NUM_ELEM*CODE_W | Per-element select codes |
| out_valid | output | 1 | Merged vector is valid |
| out_data | output | NUM_ELEM*ELEM_W | Merged vector |
| out_wen | output | NUM_ELEM | Per-element write enable |

## Verification
All results are due one clock after the edge that samples the stimulus. The bench drives inputs on the falling edge. It waits for the next rising edge and then checks out_data, out_wen and out_valid at the following falling edge, half a period after they change. After that checking point it lowers in_valid and lets one more edge pass. It then confirms that out_valid and out_wen are deasserted, so a stale result cannot hold the enables high.

// File: rtl/vmerge_pkg.sv
// Package: select-code encoding shared by the merge unit.
package vmerge_pkg;
    typedef enum logic [2:0] {
        SEL_KEEP  = 3'b000,
        SEL_NEW_A = 3'b001,
        SEL_ZERO  = 3'b010,
        SEL_NEW_B = 3'b011,
        SEL_OR    = 3'b100,
        SEL_AND   = 3'b101,
        SEL_ONES  = 3'b110,
        SEL_NEW_C = 3'b111
    } sel_code_e;
endpackage

// File: rtl/vmerge_lane.sv
// Module: vmerge_lane
// Combinational merge for one element.
// Assumes: the code is already widened to 3 bits by the caller.
module vmerge_lane
    import vmerge_pkg::*;
#(
    parameter int ELEM_W = 16
) (
    input  logic [ELEM_W-1:0] old_v,
    input  logic [ELEM_W-1:0] new_v,
    input  logic [2:0]        code,
    output logic [ELEM_W-1:0] res,
    output logic              wen
);
    // Decode the select code into the lane result.
    always_comb begin
        unique case (sel_code_e'(code))
            SEL_KEEP:  res = old_v;
            SEL_ZERO:  res = '0;
            SEL_OR:    res = old_v | new_v;
            SEL_AND:   res = old_v & new_v;
            SEL_ONES:  res = '1;
            default:   res = new_v;
        endcase
    end

    // Only the keep code suppresses the write.
    always_comb wen = (code != 3'b000);
endmodule

// File: rtl/vmerge_unit.sv
// Module: vmerge_unit
// Registered per-element merge of old and new vectors under select codes.
// Assumes: CODE_W is 2 or 3; in 2-bit mode the upper code bit is zero.
module vmerge_unit #(
    parameter int NUM_ELEM = 4,
    parameter int ELEM_W   = 16,
    parameter int CODE_W   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [NUM_ELEM*ELEM_W-1:0] in_old,
    input  logic [NUM_ELEM*ELEM_W-1:0] in_new,
    input  logic [NUM_ELEM*CODE_W-1:0] in_mask,
    output logic                       out_valid,
    output logic [NUM_ELEM*ELEM_W-1:0] out_data,
    output logic [NUM_ELEM-1:0]        out_wen
);
    localparam int VEC_W = NUM_ELEM * ELEM_W;

    logic [VEC_W-1:0]    lane_res;
    logic [NUM_ELEM-1:0] lane_wen;

    for (genvar g = 0; g < NUM_ELEM; g++) begin : g_lane
        logic [2:0] code3;
        if (CODE_W >= 3) begin : g_c3
            assign code3 = in_mask[g*CODE_W +: 3];
        end else begin : g_c2
            assign code3 = {1'b0, in_mask[g*CODE_W +: 2]};
        end
        vmerge_lane #(.ELEM_W(ELEM_W)) u_lane (
            .old_v (in_old[g*ELEM_W +: ELEM_W]),
            .new_v (in_new[g*ELEM_W +: ELEM_W]),
            .code  (code3),
            .res   (lane_res[g*ELEM_W +: ELEM_W]),
            .wen   (lane_wen[g])
        );
    end

    // Capture merged lanes and qualified write enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_wen   <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_wen   <= in_valid ? lane_wen : '0;
            if (in_valid) out_data <= lane_res;
        end
    end

    // R9
    wen_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wen != '0) |-> out_valid);
    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));
    // R2
    idle_no_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (out_wen == '0));
    // R3
    keep_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mask[CODE_W-1:0] == '0) |=> (!out_wen[0] && out_data[ELEM_W-1:0] == $past(in_old[ELEM_W-1:0])));
endmodule

// File: tb/tb_vmerge_unit.sv
module tb_vmerge_unit;
    localparam int N = 4, W = 16;
    logic clk = 0, rst_n = 0, in_valid = 0;
    logic [N*W-1:0] in_old = '0, in_new = '0;
    logic [N*3-1:0] in_mask = '0;
    logic out_valid; logic [N*W-1:0] out_data; logic [N-1:0] out_wen;
    logic [N*W-1:0] in_old2 = '0, in_new2 = '0;
    logic [N*2-1:0] in_mask2 = '0;
    logic out_valid2; logic [N*W-1:0] out_data2; logic [N-1:0] out_wen2;
    int errors = 0, checks = 0;

    always #10 clk = ~clk;

    vmerge_unit #(.NUM_ELEM(N), .ELEM_W(W), .CODE_W(3)) dut (
        .clk, .rst_n, .in_valid, .in_old, .in_new, .in_mask,
        .out_valid, .out_data, .out_wen);
    vmerge_unit #(.NUM_ELEM(N), .ELEM_W(W), .CODE_W(2)) dut2 (
        .clk, .rst_n, .in_valid, .in_old(in_old2), .in_new(in_new2),
        .in_mask(in_mask2), .out_valid(out_valid2), .out_data(out_data2),
        .out_wen(out_wen2));

    initial begin
        #4000000;
        errors++; checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] model(input logic [2:0] c, input logic [W-1:0] o, input logic [W-1:0] n);
        case (c)
            3'b000: return o;
            3'b010: return '0;
            3'b100: return o | n;
            3'b101: return o & n;
            3'b110: return '1;
            default: return n;
        endcase
    endfunction

    // Apply one vector to the 3-bit instance and check all lanes one clock later.
    task automatic run3(input string req, input logic [N*W-1:0] o, input logic [N*W-1:0] n, input logic [N*3-1:0] m);
        logic [N*W-1:0] exp_d; logic [N-1:0] exp_w;
        @(negedge clk);
        in_old = o; in_new = n; in_mask = m; in_valid = 1;
        for (int i = 0; i < N; i++) begin
            exp_d[i*W +: W] = model(m[i*3 +: 3], o[i*W +: W], n[i*W +: W]);
            exp_w[i] = (m[i*3 +: 3] != 3'b000);
        end
        @(negedge clk);
        in_valid = 0;
        chk({req, " data"}, out_data, exp_d);
        chk({req, " wen"}, out_wen, exp_w);
        chk({req, " valid"}, out_valid, 1'b1);
        @(negedge clk);
        chk({req, " R2 idle wen"}, {out_valid, out_wen}, '0);
    endtask

    task automatic t_reset;
        repeat (2) @(negedge clk);
        chk("R1 reset valid", out_valid, 0);
        chk("R1 reset wen", out_wen, 0);
        rst_n = 1;
    endtask

    task automatic t_two_bit;
        // R10: codes 00,01,10,11 on lanes 0..3
        @(negedge clk);
        in_old2 = 64'h1111_2222_3333_4444; in_new2 = 64'hAAAA_BBBB_CCCC_DDDD;
        in_mask2 = {2'b11, 2'b10, 2'b01, 2'b00}; in_valid = 1;
        @(negedge clk);
        in_valid = 0;
        chk("R10 two-bit data", out_data2, 64'hAAAA_0000_CCCC_4444);
        chk("R10 two-bit wen", out_wen2, 4'b1110);
    endtask

    localparam logic [N*W-1:0] OLDV = 64'hF0F0_1234_00FF_5A5A;
    localparam logic [N*W-1:0] NEWV = 64'h0FF0_8765_0F0F_A5A5;

    initial begin
        t_reset();
        run3("R3 R5 R4 R11 mix", OLDV, NEWV, {3'b001, 3'b010, 3'b011, 3'b000});
        run3("R6 R7 R8 R4 mix", OLDV, NEWV, {3'b110, 3'b101, 3'b100, 3'b111});
        run3("R6 or all", OLDV, NEWV, {4{3'b100}});
        run3("R7 and all", OLDV, NEWV, {4{3'b101}});
        run3("R3 R9 keep all", OLDV, NEWV, {4{3'b000}});
        run3("R8 R9 ones all", 64'h0, 64'h0, {4{3'b110}});
        run3("R5 zero all", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, {4{3'b010}});
        t_two_bit();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule